// File: doc/BRIEF.md
# DDR Mode Register Programming Sequencer

This block sits on the controller side of a DDR-style SDRAM interface. It turns one configuration request into the short command stream that sets up the memory's two mode registers. A request carries four settings: a burst length code, a burst type, a CAS latency code and a DLL-reset flag. It also carries a 12-bit word for the extended register. The block checks the codes. If they are legal, it precharges every bank and waits out the precharge time. It then loads the extended register, waits the register-load delay, loads the mode register and waits that delay again. After that it hands the bus back.

Requests arrive on a valid/ready handshake. Ready is high only while the sequencer is idle, so back-pressure lasts for a whole programming run. A requester may hold valid high, and its fields may change freely while ready is low. Only the values present on the accepting edge are used. A request with an illegal code is consumed in one cycle. It produces a one-cycle error pulse and no command. Busy and done are plain status levels. The command pins show a NOP on every cycle that carries no command.

Top module: `mrs_program_seq`

## Requirements
- R1: After reset the pins show NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1), with bank and address at 0. Busy, done and err are 0 and req_ready is 1.
- R2: req_ready is 1 exactly when the sequencer is idle. A request is taken on an edge where req_valid and req_ready are both 1. The fields are sampled on that edge, and later changes to them have no effect on the run.
- R3: In the first cycle after a legal request is taken, a precharge-all command appears: cs_n=0, ras_n=0, cas_n=1, we_n=0. Address bit 10 is 1, all other address bits are 0, and the bank is 0.
- R4: The extended register load comes TRP_CYC cycles after the precharge. Every cycle between them is a NOP.
- R5: A register load drives all four command pins low. The extended register load uses bank value 2'b01 and places req_emr_word unchanged on the address.
- R6: Each register load is followed by TMRD_CYC-1 NOP cycles. The mode register load comes exactly TMRD_CYC cycles after the extended register load.
- R7: The mode register load uses bank 2'b00. Its address layout is: bits 2:0 carry the burst length code, bit 3 the burst type, bits 6:4 the CAS latency code, bit 7 (test mode) 0, bit 8 the DLL-reset flag, and bits 11:9 are 0.
- R8: The legal burst length codes are 1, 2 and 3 (for 2, 4 and 8). The legal CAS latency codes are 3 to 6. Any other code is refused. err goes to 1 for one cycle in the cycle after the edge that took the request, no command is issued, and busy stays 0.
- R9: Busy is 1 from the precharge cycle through the last NOP after the mode register load. In the next cycle done is 1 for one cycle while busy is 0. req_ready returns to 1 in the cycle after that.
- R10: The extended register is always loaded before the mode register within a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (idle) |
| req_bl_code | input | 3 | Burst length code |
| req_bt | input | 1 | Burst type, 0 sequential, 1 interleave |
| req_cl_code | input | 3 | CAS latency code |
| req_dll_rst | input | 1 | DLL reset flag |
| req_emr_word | input | 12 | Extended register contents |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | 12 | Address bus |
| busy | output | 1 | Programming run in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle refusal pulse |

## Verification
The assertions assume that the memory is in a state where a precharge-all is allowed when a request arrives, with the clock enable already high outside this block. They also assume that TRP_CYC is at least 2, so that a wait cycle always exists. The bench starts every request from idle after reset and never drives the command bus from elsewhere. It keeps the parameters at legal values. Some requests hold valid through a whole run while the fields change, which tests back-pressure without breaking those assumptions.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  localparam int ADDR_W = 12;
  localparam int BANK_W = 2;
  localparam int PRE_ALL_BIT = 10;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  localparam cmd_pins_t CMD_NOP  = cmd_pins_t'(4'b0111);
  localparam cmd_pins_t CMD_PRE  = cmd_pins_t'(4'b0010);
  localparam cmd_pins_t CMD_LOAD = cmd_pins_t'(4'b0000);

  localparam logic [BANK_W-1:0] BANK_MODE = 2'b00;
  localparam logic [BANK_W-1:0] BANK_EXT  = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_TRP, ST_EMR, ST_MRD1, ST_MRS, ST_MRD2, ST_DONE
  } seq_state_t;
endpackage

// File: rtl/mrs_word_build.sv
module mrs_word_build
  import mrs_pkg::*;
#(
  parameter int BL_MIN = 1,
  parameter int BL_MAX = 3,
  parameter int CL_MIN = 3,
  parameter int CL_MAX = 6
) (
  input  logic [2:0]        bl_code,
  input  logic              bt,
  input  logic [2:0]        cl_code,
  input  logic              dll_rst,
  output logic [ADDR_W-1:0] word,
  output logic              legal
);
  logic bl_ok, cl_ok;

  always_comb begin
    bl_ok = (int'(bl_code) >= BL_MIN) && (int'(bl_code) <= BL_MAX);
    cl_ok = (int'(cl_code) >= CL_MIN) && (int'(cl_code) <= CL_MAX);
    legal = bl_ok && cl_ok;
    word        = '0;
    word[2:0]   = bl_code;
    word[3]     = bt;
    word[6:4]   = cl_code;
    word[7]     = 1'b0;
    word[8]     = dll_rst;
  end
endmodule

// File: rtl/mrs_wait_cnt.sv
module mrs_wait_cnt #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/mrs_cmd_mux.sv
module mrs_cmd_mux
  import mrs_pkg::*;
(
  input  seq_state_t        state,
  input  logic [ADDR_W-1:0] mr_word,
  input  logic [ADDR_W-1:0] emr_word,
  output cmd_pins_t         pins,
  output logic [BANK_W-1:0] ba,
  output logic [ADDR_W-1:0] addr
);
  always_comb begin
    pins = CMD_NOP;
    ba   = '0;
    addr = '0;
    case (state)
      ST_PRE: begin
        pins              = CMD_PRE;
        addr[PRE_ALL_BIT] = 1'b1;
      end
      ST_EMR: begin
        pins = CMD_LOAD;
        ba   = BANK_EXT;
        addr = emr_word;
      end
      ST_MRS: begin
        pins = CMD_LOAD;
        ba   = BANK_MODE;
        addr = mr_word;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mrs_program_seq.sv
module mrs_program_seq
  import mrs_pkg::*;
#(
  parameter int TRP_CYC  = 3,
  parameter int TMRD_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_bl_code,
  input  logic              req_bt,
  input  logic [2:0]        req_cl_code,
  input  logic              req_dll_rst,
  input  logic [ADDR_W-1:0] req_emr_word,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] ba,
  output logic [ADDR_W-1:0] addr,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int MAX_WAIT = (TRP_CYC > TMRD_CYC) ? TRP_CYC : TMRD_CYC;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam logic [CNT_W-1:0] TRP_LOAD  = CNT_W'(TRP_CYC - 2);
  localparam logic [CNT_W-1:0] TMRD_LOAD = CNT_W'(TMRD_CYC - 2);

  seq_state_t        state, state_nx;
  logic [ADDR_W-1:0] mr_q, emr_q, mr_word;
  logic              legal, accept, err_q;
  logic              cnt_load, cnt_zero;
  logic [CNT_W-1:0]  cnt_val;
  cmd_pins_t         pins;

  mrs_word_build u_word (
    .bl_code (req_bl_code),
    .bt      (req_bt),
    .cl_code (req_cl_code),
    .dll_rst (req_dll_rst),
    .word    (mr_word),
    .legal   (legal)
  );

  mrs_wait_cnt #(.W(CNT_W)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  mrs_cmd_mux u_mux (
    .state    (state),
    .mr_word  (mr_q),
    .emr_word (emr_q),
    .pins     (pins),
    .ba       (ba),
    .addr     (addr)
  );

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_nx = state;
    cnt_load = 1'b0;
    cnt_val  = TRP_LOAD;
    case (state)
      ST_IDLE: if (accept && legal) state_nx = ST_PRE;
      ST_PRE: begin
        state_nx = ST_TRP;
        cnt_load = 1'b1;
        cnt_val  = TRP_LOAD;
      end
      ST_TRP:  if (cnt_zero) state_nx = ST_EMR;
      ST_EMR: begin
        state_nx = ST_MRD1;
        cnt_load = 1'b1;
        cnt_val  = TMRD_LOAD;
      end
      ST_MRD1: if (cnt_zero) state_nx = ST_MRS;
      ST_MRS: begin
        state_nx = ST_MRD2;
        cnt_load = 1'b1;
        cnt_val  = TMRD_LOAD;
      end
      ST_MRD2: if (cnt_zero) state_nx = ST_DONE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      mr_q  <= '0;
      emr_q <= '0;
      err_q <= 1'b0;
    end else begin
      state <= state_nx;
      err_q <= accept && !legal;
      if (accept && legal) begin
        mr_q  <= mr_word;
        emr_q <= req_emr_word;
      end
    end
  end

  assign cs_n  = pins.cs_n;
  assign ras_n = pins.ras_n;
  assign cas_n = pins.cas_n;
  assign we_n  = pins.we_n;
  assign busy  = (state != ST_IDLE) && (state != ST_DONE);
  assign done  = (state == ST_DONE);
  assign err   = err_q;

  // Assertion support: gap since last load, and extended-load seen flag
  logic       is_load, is_nop;
  logic [3:0] since_load;
  logic       emr_seen;
  assign is_load = ({cs_n, ras_n, cas_n, we_n} == 4'b0000);
  assign is_nop  = ({cs_n, ras_n, cas_n, we_n} == 4'b0111);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_load <= 4'd15;
      emr_seen   <= 1'b0;
    end else begin
      if (is_load)                 since_load <= 4'd1;
      else if (since_load != 4'd15) since_load <= since_load + 4'd1;
      if (is_load && ba == BANK_EXT) emr_seen <= 1'b1;
      else if (done)                 emr_seen <= 1'b0;
    end
  end

  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!busy && !done));

  assert_pre_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ({cs_n, ras_n, cas_n, we_n} == 4'b0010) |-> (addr[PRE_ALL_BIT] && ba == '0));

  assert_mrd_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_nop && since_load < 4'd15) |-> (int'(since_load) >= TMRD_CYC));

  assert_mr_layout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_load && ba == BANK_MODE) |->
      (addr[11:9] == 3'b000 && !addr[7] && addr[6:4] >= 3'd3 && addr[6:4] <= 3'd6
       && addr[2:0] >= 3'd1 && addr[2:0] <= 3'd3));

  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (is_nop && !busy));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_emr_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (is_load && ba == BANK_MODE) |-> emr_seen);

  initial begin
    assert_trp_param_R4: assert (TRP_CYC >= 2 && TMRD_CYC >= 2 && TMRD_CYC <= 14);
  end
endmodule

// File: tb/test_mrs_program_seq.sv
`timescale 1ns/100ps
module test_mrs_program_seq;
  localparam int TRP  = 3;
  localparam int TMRD = 4;
  localparam int LAST = TRP + 2 * TMRD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_bl_code = '0;
  logic        req_bt = 1'b0;
  logic [2:0]  req_cl_code = '0;
  logic        req_dll_rst = 1'b0;
  logic [11:0] req_emr_word = '0;
  logic        cs_n, ras_n, cas_n, we_n, busy, done, err;
  logic [1:0]  ba;
  logic [11:0] addr;

  int checks = 0;
  int fails  = 0;

  mrs_program_seq #(.TRP_CYC(TRP), .TMRD_CYC(TMRD)) i_mrs_program_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bl_code(req_bl_code), .req_bt(req_bt), .req_cl_code(req_cl_code),
    .req_dll_rst(req_dll_rst), .req_emr_word(req_emr_word),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .busy(busy), .done(done), .err(err)
  );

  function automatic logic [17:0] bus_now();
    return {cs_n, ras_n, cas_n, we_n, ba, addr};
  endfunction

  localparam logic [17:0] BUS_NOP = {4'b0111, 2'b00, 12'h000};

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [17:0] exp_bus(int o, logic [11:0] mr, logic [11:0] emr);
    if (o == 0)         return {4'b0010, 2'b00, 12'h400};
    if (o == TRP)       return {4'b0000, 2'b01, emr};
    if (o == TRP + TMRD) return {4'b0000, 2'b00, mr};
    return BUS_NOP;
  endfunction

  task automatic test_reset();
    @(negedge clk);
    chk(bus_now() == BUS_NOP, "R1", "bus", 32'(bus_now()), 32'(BUS_NOP));
    chk({busy, done, err, req_ready} == 4'b0001, "R1", "status",
        32'({busy, done, err, req_ready}), 32'h1);
  endtask

  // One legal run; hold=1 keeps valid high through the run (back-pressure)
  task automatic run_prog(input logic [2:0] bl, input logic bt, input logic [2:0] cl,
                          input logic dll, input logic [11:0] emr, input bit hold);
    logic [11:0] mr;
    logic [17:0] eb;
    mr = {3'b000, dll, 1'b0, cl, bt, bl};
    @(negedge clk);
    chk(req_ready == 1'b1, "R2", "ready before", 32'(req_ready), 32'h1);
    req_valid = 1'b1; req_bl_code = bl; req_bt = bt; req_cl_code = cl;
    req_dll_rst = dll; req_emr_word = emr;
    for (int o = 0; o <= LAST; o++) begin
      @(negedge clk);
      if (o == 0) begin
        // change fields after acceptance: run must not follow them (R2)
        req_valid = hold; req_bl_code = 3'd2; req_bt = ~bt; req_cl_code = 3'd5;
        req_dll_rst = ~dll; req_emr_word = ~emr;
      end
      eb = exp_bus(o, mr, emr);
      chk(bus_now() == eb, (o == 0) ? "R3" : (o == TRP) ? "R5" :
          (o == TRP + TMRD) ? "R7" : (o < TRP) ? "R4" : "R6",
          $sformatf("bus offset %0d", o), 32'(bus_now()), 32'(eb));
      chk(busy == (o < LAST) && done == (o == LAST), "R9",
          $sformatf("busy/done offset %0d", o), 32'({busy, done}),
          32'({(o < LAST), (o == LAST)}));
      chk(req_ready == 1'b0, "R2", $sformatf("ready offset %0d", o), 32'(req_ready), 32'h0);
    end
    @(negedge clk);
    chk(req_ready == 1'b1 && bus_now() == BUS_NOP && !done, "R9", "back to idle",
        32'({req_ready, done}), 32'h2);
    if (hold) begin
      @(negedge clk);
      chk(bus_now() == exp_bus(0, mr, emr), "R2", "held request accepted",
          32'(bus_now()), 32'(exp_bus(0, mr, emr)));
      req_valid = 1'b0;
      repeat (LAST + 2) @(negedge clk);
    end
  endtask

  task automatic reject(input logic [2:0] bl, input logic [2:0] cl);
    @(negedge clk);
    req_valid = 1'b1; req_bl_code = bl; req_cl_code = cl; req_bt = 1'b0;
    req_dll_rst = 1'b0; req_emr_word = 12'hFFF;
    @(negedge clk);
    req_valid = 1'b0;
    chk(err == 1'b1 && busy == 1'b0, "R8", $sformatf("refuse bl=%0d cl=%0d", bl, cl),
        32'({err, busy}), 32'h2);
    chk(bus_now() == BUS_NOP, "R8", "no command on refuse", 32'(bus_now()), 32'(BUS_NOP));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(err == 1'b0 && bus_now() == BUS_NOP && !busy, "R8", "quiet after refuse",
          32'({err, busy}), 32'h0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    test_reset();
    run_prog(3'd1, 1'b0, 3'd3, 1'b1, 12'h000, 1'b0);
    run_prog(3'd3, 1'b1, 3'd6, 1'b0, 12'h002, 1'b0);
    run_prog(3'd2, 1'b0, 3'd4, 1'b0, 12'hA5A, 1'b1);
    reject(3'd0, 3'd3);
    reject(3'd4, 3'd5);
    reject(3'd7, 3'd4);
    reject(3'd2, 3'd2);
    reject(3'd2, 3'd7);
    run_prog(3'd3, 1'b0, 3'd5, 1'b1, 12'h001, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule